// File: doc/BRIEF.md
# Stereo Digital Zero-Input Detector

This block watches a stereo PCM stream, one left and one right sample per frame strobe, and raises a single registered flag once both channels have carried all-zero words for a long unbroken run of frames. Downstream logic uses the flag to mute or power down an output path while the source is silent. The flag falls in the very cycle that follows a strobe carrying a nonzero word on either side, so audio is never held off after it resumes.

A control bit, `run_en`, acts as a soft reset. While it is low the flag is forced high and the run count is cleared. When the bit returns high, the flag stays high for a few frames and then drops. From that point a complete fresh run of silent frames is needed before it can rise again. Sample width, run length and release delay are parameters. Samples are examined only on a strobe; between strobes all state holds.

Top module: `dzd_detector`

## Requirements
- R1: With `run_en` high and the block settled, `zero_flag` rises in the clock cycle after the strobe that completes exactly RUN_FRAMES consecutive frames in which both `left_smp` and `right_smp` equal zero, and not after fewer.
- R2: Once the block has settled, a strobe on which either sample is nonzero drives `zero_flag` low in the following cycle, with no frame of delay.
- R3: While `run_en` is 0, `zero_flag` is 1 from the next clock on, whatever the sample data and strobe.
- R4: After `run_en` returns to 1, `zero_flag` stays 1 through the first RELEASE_FRAMES strobes and goes to 0 after strobe number RELEASE_FRAMES+1. With the default of 4 this gives a delay of 4 to 5 frame periods.
- R5: A frame in which only one channel is zero breaks the run: the count restarts and a full RUN_FRAMES of two-channel zero frames is needed afterwards.
- R6: The run count saturates at RUN_FRAMES and never wraps, so the flag stays 1 through any number of further zero frames.
- R7: Between strobes `zero_flag` keeps its value whatever the sample inputs do.
- R8: Zero frames seen while `run_en` is 0 or during the release window do not count toward a run. After the flag drops at release, RUN_FRAMES fresh zero frames are needed.
- R9: While `rst_n` is low, `zero_flag` is 1. The block then behaves as after a soft reset that was released on the first clock with `rst_n` high and `run_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of all registers |
| run_en | input | 1 | Soft reset control; 0 forces the flag high and clears the run |
| frame_stb | input | 1 | One-cycle pulse per sample period; samples are taken on it |
| left_smp | input | SAMPLE_W | Left channel sample word |
| right_smp | input | SAMPLE_W | Right channel sample word |
| zero_flag | output | 1 | Registered zero-input flag |

## Verification
The bench builds the block with SAMPLE_W of 4, RUN_FRAMES of 8 and RELEASE_FRAMES of 2. With a run that short, every run length from zero to just past the threshold can be swept. The small sample width lets all 256 left/right pairs be applied against a raised flag. Saturation is reached quickly, and long runs of several times the threshold show that the count does not wrap. The short release window lets the bench count strobes around the soft reset exactly, including silent data that arrives during the hold.

// File: rtl/dzd_pkg.sv
package dzd_pkg;

   typedef enum logic [1:0] {
      PH_HOLD    = 2'd0,
      PH_RELEASE = 2'd1,
      PH_ACTIVE  = 2'd2
   } dzd_phase_e;

endpackage

// File: rtl/dzd_zero_detect.sv
module dzd_zero_detect #(
   parameter int SAMPLE_W = 24,
   parameter int NUM_CH   = 2
) (
   input  logic [NUM_CH*SAMPLE_W-1:0] smp_flat,
   output logic                       all_zero
);

   logic [NUM_CH-1:0] ch_zero;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         assign ch_zero[ch] = ~|smp_flat[ch*SAMPLE_W +: SAMPLE_W];
      end
   endgenerate

   assign all_zero = &ch_zero;

endmodule

// File: rtl/dzd_release_ctrl.sv
module dzd_release_ctrl
   import dzd_pkg::*;
#(
   parameter int RELEASE_FRAMES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_en,
   input  logic       frame_stb,
   output dzd_phase_e phase,
   output logic       release_done
);

   localparam int REL_W = $clog2(RELEASE_FRAMES + 1);
   localparam logic [REL_W-1:0] REL_LAST = REL_W'(RELEASE_FRAMES);

   logic [REL_W-1:0] rel_cnt;

   assign release_done = run_en && frame_stb && (phase == PH_RELEASE)
                         && (rel_cnt == REL_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_HOLD;
         rel_cnt <= '0;
      end else if (!run_en) begin
         phase   <= PH_HOLD;
         rel_cnt <= '0;
      end else begin
         unique case (phase)
            PH_HOLD: begin
               phase   <= PH_RELEASE;
               rel_cnt <= '0;
            end
            PH_RELEASE: begin
               if (frame_stb) begin
                  if (rel_cnt == REL_LAST) begin
                     phase <= PH_ACTIVE;
                  end else begin
                     rel_cnt <= rel_cnt + 1'b1;
                  end
               end
            end
            default: phase <= PH_ACTIVE;
         endcase
      end
   end

endmodule

// File: rtl/dzd_run_counter.sv
module dzd_run_counter #(
   parameter int RUN_FRAMES = 8192,
   localparam int RUN_W = $clog2(RUN_FRAMES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic             zero_in,
   output logic             reach,
   output logic [RUN_W-1:0] run_cnt
);

   localparam logic [RUN_W-1:0] CNT_LAST = RUN_W'(RUN_FRAMES - 1);
   localparam logic [RUN_W-1:0] CNT_SAT  = RUN_W'(RUN_FRAMES);

   assign reach = zero_in && (run_cnt >= CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (clear) begin
         run_cnt <= '0;
      end else if (step) begin
         if (!zero_in) begin
            run_cnt <= '0;
         end else if (run_cnt != CNT_SAT) begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/dzd_detector.sv
module dzd_detector
   import dzd_pkg::*;
#(
   parameter int SAMPLE_W       = 24,
   parameter int RUN_FRAMES     = 8192,
   parameter int RELEASE_FRAMES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run_en,
   input  logic                frame_stb,
   input  logic [SAMPLE_W-1:0] left_smp,
   input  logic [SAMPLE_W-1:0] right_smp,
   output logic                zero_flag
);

   localparam int NUM_CH = 2;
   localparam int RUN_W  = $clog2(RUN_FRAMES + 1);

   generate
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("dzd_detector: SAMPLE_W must be at least 1");
      end
      if (RUN_FRAMES < 2) begin : g_bad_run
         $error("dzd_detector: RUN_FRAMES must be at least 2");
      end
      if (RELEASE_FRAMES < 1) begin : g_bad_rel
         $error("dzd_detector: RELEASE_FRAMES must be at least 1");
      end
   endgenerate

   dzd_phase_e       phase;
   logic             release_done;
   logic             all_zero;
   logic             reach;
   logic [RUN_W-1:0] run_cnt;
   logic             active;

   assign active = run_en && (phase == PH_ACTIVE);

   dzd_zero_detect #(
      .SAMPLE_W (SAMPLE_W),
      .NUM_CH   (NUM_CH)
   ) u_zero (
      .smp_flat ({right_smp, left_smp}),
      .all_zero (all_zero)
   );

   dzd_release_ctrl #(
      .RELEASE_FRAMES (RELEASE_FRAMES)
   ) u_release (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_en       (run_en),
      .frame_stb    (frame_stb),
      .phase        (phase),
      .release_done (release_done)
   );

   dzd_run_counter #(
      .RUN_FRAMES (RUN_FRAMES)
   ) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!active),
      .step    (frame_stb),
      .zero_in (all_zero),
      .reach   (reach),
      .run_cnt (run_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_flag <= 1'b1;
      end else if (!run_en) begin
         zero_flag <= 1'b1;
      end else if (release_done) begin
         zero_flag <= 1'b0;
      end else if (active && frame_stb) begin
         zero_flag <= reach;
      end
   end

endmodule

// File: rtl/dzd_detector_chk.sv
module dzd_detector_chk
   import dzd_pkg::*;
#(
   parameter int SAMPLE_W   = 24,
   parameter int RUN_FRAMES = 8192,
   localparam int RUN_W = $clog2(RUN_FRAMES + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                run_en,
   input logic                frame_stb,
   input logic [SAMPLE_W-1:0] left_smp,
   input logic [SAMPLE_W-1:0] right_smp,
   input logic                zero_flag,
   input dzd_phase_e          phase,
   input logic [RUN_W-1:0]    run_cnt
);

   localparam logic [RUN_W-1:0] CHK_LAST = RUN_W'(RUN_FRAMES - 1);
   localparam logic [RUN_W-1:0] CHK_SAT  = RUN_W'(RUN_FRAMES);

   logic both_zero;
   assign both_zero = (left_smp == '0) && (right_smp == '0);

   assert_run_reached_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && frame_stb && phase == PH_ACTIVE && both_zero && run_cnt == CHK_LAST)
      |=> zero_flag);

   assert_nonzero_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && frame_stb && phase == PH_ACTIVE && !both_zero) |=> !zero_flag);

   assert_hold_forces_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> zero_flag);

   assert_release_keeps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_ACTIVE) |-> zero_flag);

   assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CHK_SAT);

   assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !frame_stb) |=> $stable(zero_flag));

   assert_fresh_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_ACTIVE) |=> (run_cnt == '0));

endmodule

bind dzd_detector dzd_detector_chk #(
   .SAMPLE_W   (SAMPLE_W),
   .RUN_FRAMES (RUN_FRAMES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_en    (run_en),
   .frame_stb (frame_stb),
   .left_smp  (left_smp),
   .right_smp (right_smp),
   .zero_flag (zero_flag),
   .phase     (phase),
   .run_cnt   (run_cnt)
);

// File: tb/dzd_detector_bench.sv
`timescale 1ns/1ps
module dzd_detector_bench;

   localparam int SW  = 4;
   localparam int RUN = 8;
   localparam int REL = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_en = 1'b0;
   logic          frame_stb = 1'b0;
   logic [SW-1:0] left_smp = '0;
   logic [SW-1:0] right_smp = '0;
   logic          zero_flag;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   dzd_detector #(
      .SAMPLE_W       (SW),
      .RUN_FRAMES     (RUN),
      .RELEASE_FRAMES (REL)
   ) u_dzd_detector (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .frame_stb (frame_stb),
      .left_smp  (left_smp),
      .right_smp (right_smp),
      .zero_flag (zero_flag)
   );

   task automatic chk(input logic exp, input string req, input string what);
      n_checks++;
      if (zero_flag !== exp) begin
         n_fail++;
         $display("FAIL %s %s: zero_flag=%b expected %b", req, what, zero_flag, exp);
      end
   endtask

   // one frame: strobe for one clock, then two idle clocks
   task automatic frame(input logic [SW-1:0] l, input logic [SW-1:0] r);
      @(negedge clk);
      frame_stb = 1'b1;
      left_smp  = l;
      right_smp = r;
      @(negedge clk);
      frame_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic zeros(input int n);
      for (int i = 0; i < n; i++) frame('0, '0);
   endtask

   // soft reset, then walk the release window
   task automatic soft_reset(input logic [SW-1:0] hold_data);
      @(negedge clk);
      run_en = 1'b0;
      frame(hold_data, hold_data);
      chk(1'b1, "R3", "hold with data");
      @(negedge clk);
      run_en = 1'b1;
      for (int i = 1; i <= REL; i++) begin
         frame('0, '0);
         chk(1'b1, "R4", $sformatf("release strobe %0d", i));
      end
      frame('0, '0);
      chk(1'b0, "R4", "after release window");
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(1'b1, "R9", "during rst_n");
      rst_n  = 1'b1;
      run_en = 1'b1;
      for (int i = 1; i <= REL; i++) begin
         frame('0, '0);
         chk(1'b1, "R9", $sformatf("release strobe %0d after rst_n", i));
      end
      frame('0, '0);
      chk(1'b0, "R9", "flag low after reset release");

      // R8: release strobes carried zeros, yet a full run is needed
      zeros(RUN - 1);
      chk(1'b0, "R8", "one short of run after release");
      zeros(1);
      chk(1'b1, "R8", "full fresh run");

      // R1: run length sweep
      for (int n = 0; n <= RUN + 2; n++) begin
         frame(4'd1, 4'd0);
         zeros(n);
         chk((n >= RUN) ? 1'b1 : 1'b0, "R1", $sformatf("run of %0d zero frames", n));
      end

      // R2: every left/right pair against a raised flag
      for (int l = 0; l < (1 << SW); l++) begin
         for (int r = 0; r < (1 << SW); r++) begin
            frame(4'd3, 4'd3);
            zeros(RUN);
            frame(SW'(l), SW'(r));
            chk((l == 0 && r == 0) ? 1'b1 : 1'b0, "R2", $sformatf("pair l=%0d r=%0d", l, r));
         end
      end

      // R5: single-channel zero frames break the run
      frame(4'd1, 4'd1);
      zeros(RUN - 1);
      frame(4'd0, 4'd5);
      zeros(RUN - 1);
      chk(1'b0, "R5", "left zero only breaks run");
      zeros(1);
      chk(1'b1, "R5", "full run after left-only break");
      frame(4'd7, 4'd0);
      zeros(RUN - 1);
      chk(1'b0, "R5", "right zero only breaks run");

      // R6: saturation, no wrap across many zero frames
      frame(4'd2, 4'd2);
      zeros(4 * RUN + 3);
      chk(1'b1, "R6", "long run stays high");
      frame(4'd0, 4'd1);
      zeros(RUN - 1);
      chk(1'b0, "R6", "after break, short run low");
      zeros(1);
      chk(1'b1, "R6", "after break, full run high");

      // R7: nonzero data without strobe has no effect
      @(negedge clk);
      left_smp  = 4'hF;
      right_smp = 4'hA;
      repeat (6) @(negedge clk);
      chk(1'b1, "R7", "high flag holds between strobes");
      frame(4'd9, 4'd0);
      @(negedge clk);
      left_smp  = '0;
      right_smp = '0;
      repeat (6) @(negedge clk);
      chk(1'b0, "R7", "low flag holds between strobes");

      // R3/R4/R8: soft reset with nonzero and zero data in hold
      soft_reset(4'd6);
      soft_reset(4'd0);
      zeros(RUN - 1);
      chk(1'b0, "R8", "hold zeros not counted");
      zeros(1);
      chk(1'b1, "R8", "fresh run after soft reset");

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule